// File: doc/BRIEF.md
# Auto-Increment Internal Memory Window

This block gives a host an indirect path into a device-internal single-port synchronous SRAM through four registers: a read pointer, a write pointer, a write-data port and a read-data port. The host loads a pointer once. After that, each access to a data port moves one 32-bit word and steps the matching pointer forward by four bytes. A long upload or a memory dump therefore needs no address write per word.

The read side keeps a one-word prefetch buffer. Loading the read pointer starts an SRAM read of that word in the same cycle. Each read of the read-data port returns the buffered word and starts the fetch of the next one. The SRAM's one-cycle read latency is hidden from a host that streams one read per cycle. The host bus has separate write and read strobes, so one write and one read may arrive together. When an SRAM write and a prefetch compete for the single SRAM port, the write goes first and the prefetch follows one cycle later.

Top module: `sram_window`

## Requirements
- R1: After reset both pointers read back as 0 and the SRAM port is idle (mem_en = 0) while no host access occurs.
- R2: A write to the read-pointer register (offset 0x40C) loads the pointer with bits 1:0 cleared. Reading that offset returns the current read pointer.
- R3: A write to the write-pointer register (offset 0x410) loads the pointer with bits 1:0 cleared. Reading that offset returns the current write pointer.
- R4: A write to the write-data register (offset 0x418) drives an SRAM write in the same cycle, at word address = write pointer bits MEM_AW+1:2, with the host data. The write pointer then advances by 4.
- R5: A write to the read-pointer register starts an SRAM read of the new word in the same cycle. That word is returned by the read-data register (offset 0x41C) from the next cycle on.
- R6: A read of the read-data register returns the prefetched word, advances the read pointer by 4 and starts the read of the following word in the same cycle, so reads on consecutive cycles return consecutive words.
- R7: If a write-data write and a prefetch fall in the same cycle, the SRAM write is issued in that cycle and the prefetch in the next cycle. A prefetch of the word just written returns the new data.
- R8: If the read pointer is written in the same cycle as the read-data register is read, the read returns the previously buffered word and the pointer takes the written value without advancing.
- R9: Pointers advance modulo 2^32: a pointer at 0xFFFFFFFC becomes 0 after one data access.
- R10: A write to the read-data offset changes no pointer and issues no SRAM access. A read of the write-data offset returns 0 and advances nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_wr_addr | input | OFS_W | Host write register offset |
| hst_wr_data | input | 32 | Host write data |
| hst_rd_en | input | 1 | Host register read strobe |
| hst_rd_addr | input | OFS_W | Host read register offset |
| hst_rd_data | output | 32 | Read data for hst_rd_addr, valid in the same cycle |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | MEM_AW | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, valid the cycle after the read |

## Verification
The SRAM strobes and the host read data are combinational in the access cycle. The bench drives each access on the falling edge and samples these outputs one time step later, before the next rising edge. Pointer updates appear on the next readback. Prefetched words are due one cycle after the prefetch is issued, and a prefetch pushed back by a write-data collision issues one cycle late. The collision scenario therefore checks the SRAM strobes in the collision cycle and in the cycle after it before it reads the data.

// File: rtl/sram_window.sv
module sram_window #(
  parameter int MEM_AW = 10,
  parameter int OFS_W  = 12,
  parameter logic [OFS_W-1:0] OFS_RPTR = 12'h40C,
  parameter logic [OFS_W-1:0] OFS_WPTR = 12'h410,
  parameter logic [OFS_W-1:0] OFS_WDAT = 12'h418,
  parameter logic [OFS_W-1:0] OFS_RDAT = 12'h41C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_wr_en,
  input  logic [OFS_W-1:0]  hst_wr_addr,
  input  logic [31:0]       hst_wr_data,
  input  logic              hst_rd_en,
  input  logic [OFS_W-1:0]  hst_rd_addr,
  output logic [31:0]       hst_rd_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam logic [31:0] STEP = 32'd4;

  logic [31:0] rptr, wptr, rbuf, rptr_nxt, wptr_nxt, rword;
  logic        pend_q, rdq;
  logic        ld_rptr, ld_wptr, put_word, take_word, pf_req;

  assign ld_rptr   = hst_wr_en && (hst_wr_addr == OFS_RPTR);
  assign ld_wptr   = hst_wr_en && (hst_wr_addr == OFS_WPTR);
  assign put_word  = hst_wr_en && (hst_wr_addr == OFS_WDAT);
  assign take_word = hst_rd_en && (hst_rd_addr == OFS_RDAT);

  assign rptr_nxt = ld_rptr   ? {hst_wr_data[31:2], 2'b00} :
                    take_word ? rptr + STEP : rptr;
  assign wptr_nxt = ld_wptr   ? {hst_wr_data[31:2], 2'b00} :
                    put_word  ? wptr + STEP : wptr;

  assign pf_req    = ld_rptr || take_word || pend_q;
  assign mem_en    = put_word || pf_req;
  assign mem_we    = put_word;
  assign mem_addr  = put_word ? wptr[MEM_AW+1:2] : rptr_nxt[MEM_AW+1:2];
  assign mem_wdata = hst_wr_data;

  assign rword = rdq ? mem_rdata : rbuf;

  always_comb begin
    case (hst_rd_addr)
      OFS_RPTR: hst_rd_data = rptr;
      OFS_WPTR: hst_rd_data = wptr;
      OFS_RDAT: hst_rd_data = rword;
      default:  hst_rd_data = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr   <= 32'd0;
      wptr   <= 32'd0;
      rbuf   <= 32'd0;
      pend_q <= 1'b0;
      rdq    <= 1'b0;
    end else begin
      rptr   <= rptr_nxt;
      wptr   <= wptr_nxt;
      pend_q <= pf_req && put_word;
      rdq    <= pf_req && !put_word;
      if (rdq) rbuf <= mem_rdata;
    end
  end

  AST_WRITE_ISSUED: assert property (@(posedge clk) disable iff (rst)
    put_word |-> (mem_en && mem_we && mem_addr == wptr[MEM_AW+1:2])); // R4
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    put_word |=> (wptr == $past(wptr) + STEP)); // R4
  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (take_word && !ld_rptr) |=> (rptr == $past(rptr) + STEP)); // R6
  AST_LOAD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ld_rptr |=> (rptr[1:0] == 2'b00)); // R2
  AST_DEFERRED_FETCH: assert property (@(posedge clk) disable iff (rst)
    (put_word && (ld_rptr || take_word)) |=> mem_en); // R7
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (hst_wr_en && hst_wr_addr == OFS_RDAT && !take_word) |=> ($stable(rptr) && $stable(wptr))); // R10
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en); // R4
endmodule

// File: tb/sram_window_tb.sv
module sram_window_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [11:0] A_RPTR = 12'h40C, A_WPTR = 12'h410,
                          A_WDAT = 12'h418, A_RDAT = 12'h41C;

  logic clk = 1'b0, rst = 1'b1;
  logic hst_wr_en = 1'b0, hst_rd_en = 1'b0;
  logic [11:0] hst_wr_addr = '0, hst_rd_addr = '0;
  logic [31:0] hst_wr_data = '0, hst_rd_data;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] smem [DEPTH];

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] c_rd, c_wdata;
  logic c_en, c_we;
  logic [AW-1:0] c_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_window #(.MEM_AW(AW)) u_dut (
    .clk(clk), .rst(rst),
    .hst_wr_en(hst_wr_en), .hst_wr_addr(hst_wr_addr), .hst_wr_data(hst_wr_data),
    .hst_rd_en(hst_rd_en), .hst_rd_addr(hst_rd_addr), .hst_rd_data(hst_rd_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] init_word(input int i);
    return 32'hA500_0000 ^ (i * 32'h0001_0003);
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) smem[i] = init_word(i);
  end

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) smem[mem_addr] <= mem_wdata;
      else        mem_rdata <= smem[mem_addr];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [11:0] wa, input logic [31:0] wd,
                      input bit re, input logic [11:0] ra);
    @(negedge clk);
    hst_wr_en = we; hst_wr_addr = wa; hst_wr_data = wd;
    hst_rd_en = re; hst_rd_addr = ra;
    #1;
    c_rd = hst_rd_data; c_en = mem_en; c_we = mem_we;
    c_addr = mem_addr; c_wdata = mem_wdata;
    @(posedge clk);
    #1;
    hst_wr_en = 0; hst_rd_en = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d); step(1, a, d, 0, 12'h0); endtask
  task automatic rd(input logic [11:0] a); step(0, 12'h0, 0, 1, a); endtask

  task automatic t_reset;
    rd(A_RPTR); chk("R1 rptr", c_rd, 0); chk("R1 idle", {31'd0, c_en}, 0);
    rd(A_WPTR); chk("R1 wptr", c_rd, 0);
  endtask

  task automatic t_burst_write;
    wr(A_WPTR, 32'h0000_0103);
    rd(A_WPTR); chk("R3 align", c_rd, 32'h100);
    for (int k = 0; k < 4; k++) begin
      wr(A_WDAT, 32'h1111_0000 + k);
      chk("R4 we", {30'd0, c_en, c_we}, 32'd3);
      chk("R4 addr", {22'd0, c_addr}, 32'h40 + k);
      chk("R4 data", c_wdata, 32'h1111_0000 + k);
    end
    rd(A_WPTR); chk("R4 wptr", c_rd, 32'h110);
  endtask

  task automatic t_stream_read;
    wr(A_RPTR, 32'h0000_0101);
    chk("R5 fetch", {21'd0, c_en, c_we, c_addr}, {21'd0, 1'b1, 1'b0, 10'h40});
    rd(A_RPTR); chk("R2 align", c_rd, 32'h100);
    for (int k = 0; k < 4; k++) begin
      rd(A_RDAT); chk("R6 word", c_rd, 32'h1111_0000 + k);
    end
    rd(A_RPTR); chk("R6 rptr", c_rd, 32'h110);
  endtask

  task automatic t_collision;
    wr(A_WPTR, 32'h204);
    wr(A_RPTR, 32'h200);
    step(0, 12'h0, 0, 0, 12'h0);
    step(1, A_WDAT, 32'hCAFE_F00D, 1, A_RDAT);
    chk("R7 old word", c_rd, init_word(32'h80));
    chk("R7 write first", {21'd0, c_en, c_we, c_addr}, {21'd0, 1'b1, 1'b1, 10'h81});
    step(0, 12'h0, 0, 0, 12'h0);
    chk("R7 late fetch", {21'd0, c_en, c_we, c_addr}, {21'd0, 1'b1, 1'b0, 10'h81});
    rd(A_RDAT); chk("R7 new data", c_rd, 32'hCAFE_F00D);
  endtask

  task automatic t_load_and_take;
    wr(A_RPTR, 32'h280);
    step(1, A_RPTR, 32'h300, 1, A_RDAT);
    chk("R8 old word", c_rd, init_word(32'hA0));
    rd(A_RDAT); chk("R8 new word", c_rd, init_word(32'hC0));
    rd(A_RPTR); chk("R8 rptr", c_rd, 32'h304);
  endtask

  task automatic t_wrap;
    wr(A_RPTR, 32'hFFFF_FFFE);
    rd(A_RPTR); chk("R9 align", c_rd, 32'hFFFF_FFFC);
    rd(A_RDAT); chk("R9 top word", c_rd, init_word(DEPTH - 1));
    rd(A_RPTR); chk("R9 rptr wrap", c_rd, 0);
    wr(A_WPTR, 32'hFFFF_FFFC);
    wr(A_WDAT, 32'h5A5A_0001); chk("R9 top addr", {22'd0, c_addr}, DEPTH - 1);
    rd(A_WPTR); chk("R9 wptr wrap", c_rd, 0);
  endtask

  task automatic t_ignored;
    wr(A_RPTR, 32'h300);
    step(0, 12'h0, 0, 0, 12'h0);
    wr(A_RDAT, 32'h0000_DEAD); chk("R10 no access", {31'd0, c_en}, 0);
    rd(A_RPTR); chk("R10 rptr kept", c_rd, 32'h300);
    rd(A_WPTR); chk("R10 wptr kept", c_rd, 0);
    rd(A_WDAT); chk("R10 wdat reads 0", c_rd, 0);
    rd(A_RDAT); chk("R10 no advance", c_rd, init_word(32'hC0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_burst_write();
    t_stream_read();
    t_collision();
    t_load_and_take();
    t_wrap();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule